// File: doc/BRIEF.md
# Sliding-Window Sample FIFO

This block is a synchronous first-in first-out store for sample streams. It lives in a RAM region whose base address is aligned to the configured depth. One port pushes one element per cycle. The other port reads a window of N consecutive elements, oldest first, and streams them out on N back-to-back cycles.

The read side has two modes. A block read consumes the whole window. A tap read hands over the same window but retires only its oldest element, so the next tap read returns a window shifted by one sample. That is the access pattern of a FIR or smoothing filter.

The block keeps an occupancy count, empty and full flags, and a sticky error flag. An illegal operation is dropped and only raises that flag. The read and write positions are exported as RAM addresses.

Top module: `wfifo_top`

## Requirements
- R1: After reset the count is 0, empty is 1, full, err, busy and rd_valid are 0, and both pointers equal the aligned base address.
- R2: A write while not full stores wr_data, raises count by one and advances the write offset by one, wrapping modulo the depth.
- R3: full is 1 exactly when count equals the depth. A write while full is dropped: err is set, and count, pointers and stored data are unchanged.
- R4: A block read (rd_mode=0) with window N is accepted on a clock edge when idle. The element at offset k is presented with rd_valid=1 after the (k+2)-th edge counted from that acceptance edge. rd_last marks the N-th element. Count then falls by N and the read offset advances by N.
- R5: A tap read (rd_mode=1) streams the same N elements but retires only one, so count falls by 1 and the read offset advances by 1, wrapping modulo the depth.
- R6: A read request with window 0, or with a window larger than the count (including reads while empty), is aborted. err is set, no element is streamed, and count and pointers are unchanged.
- R7: err stays set until err_clr is asserted. If an error and err_clr occur in the same cycle, err stays set.
- R8: Each pointer is cfg_base with its low log2(depth) bits replaced by the offset. The low bits of cfg_base below the depth are ignored.
- R9: The depth is 2 to the power cfg_depth_log2. Values above ADDR_W are clamped to ADDR_W. The setting is changed only while the FIFO is empty.
- R10: While a window is streaming (busy=1), rd_req is ignored, but writes are still accepted and become readable after the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | RAM base address of the region |
| cfg_depth_log2 | input | LOG_W | log2 of the depth |
| cfg_win | input | ADDR_W+1 | Window size N for the next read |
| wr_en | input | 1 | Push one element |
| wr_data | input | DATA_W | Element to push |
| rd_req | input | 1 | Request a window read |
| rd_mode | input | 1 | 0 block read, 1 tap read |
| err_clr | input | 1 | Clear the error flag |
| rd_data | output | DATA_W | Streamed element |
| rd_valid | output | 1 | rd_data holds a window element |
| rd_last | output | 1 | Final element of the window |
| busy | output | 1 | A window is being streamed |
| empty | output | 1 | No element stored |
| full | output | 1 | Count equals the depth |
| err | output | 1 | Sticky error flag |
| count | output | ADDR_W+1 | Stored element count |
| rd_ptr | output | ADDR_W | RAM address of the oldest element |
| wr_ptr | output | ADDR_W | RAM address of the next write |

## Verification
The first pattern is a block read of three elements, followed by two tap reads of four elements each. It tells window consumption apart from single-step retirement, because the second tap window must overlap the first by three samples. A tap read across the end of the region and a 64-deep fill and drain show that offsets wrap and that the depth clamp works. Short windows, a zero window and reads while empty must leave count and pointers intact. This separates an abort from a partial read. A request and a write issued during a stream separate "ignored" from "queued".

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_STREAM = 1'b1
  } wfifo_state_e;
endpackage

// File: rtl/wfifo_rst_sync.sv
module wfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wfifo_map.sv
module wfifo_map #(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] off,
  output logic [ADDR_W-1:0] phys
);
  // region is aligned to its size: upper bits from base, lower bits from offset
  assign phys = (base & ~mask) | (off & mask);
endmodule

// File: rtl/wfifo_store.sv
module wfifo_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              rlast,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_last
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rdat_q;
  logic              rval_q, rlst_q;

  // storage array and read data: no reset, clock enables explicit
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    if (re) rdat_q <= mem_q[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rval_q <= 1'b0;
      rlst_q <= 1'b0;
    end else begin
      rval_q <= re;
      rlst_q <= re & rlast;
    end
  end

  assign rd_data  = rdat_q;
  assign rd_valid = rval_q;
  assign rd_last  = rlst_q;

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid); // R4
endmodule

// File: rtl/wfifo_ctrl.sv
module wfifo_ctrl
  import wfifo_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LOG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  cfg_depth_log2,
  input  logic [ADDR_W:0]   cfg_win,
  input  logic              wr_en,
  input  logic              rd_req,
  input  logic              rd_mode,
  input  logic              err_clr,
  output logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] wr_off,
  output logic [ADDR_W-1:0] rd_off,
  output logic [ADDR_W-1:0] rd_addr_off,
  output logic              wr_go,
  output logic              rd_issue,
  output logic              rd_issue_last,
  output logic [ADDR_W:0]   count,
  output logic              busy,
  output logic              empty,
  output logic              full,
  output logic              err
);
  localparam logic [LOG_W-1:0] LG_MAX = LOG_W'(ADDR_W);
  localparam logic [ADDR_W:0]  ONE_C  = (ADDR_W+1)'(1);

  wfifo_state_e      state_q, state_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [ADDR_W:0]   win_q, win_d;
  logic              mode_q, mode_d;
  logic [ADDR_W-1:0] wr_off_q, wr_off_d;
  logic [ADDR_W-1:0] rd_off_q, rd_off_d;
  logic [ADDR_W:0]   count_q, count_d;
  logic              err_q, err_d;

  logic [LOG_W-1:0]  lg_eff;
  logic [ADDR_W:0]   depth, depth_m1;
  logic              wr_bad, start, win_ok, rd_go, rd_bad, fin;
  logic [ADDR_W:0]   popn, pop_amt, wr_sum, rd_sum;

  // depth decode with clamp
  always_comb begin
    lg_eff   = (cfg_depth_log2 > LG_MAX) ? LG_MAX : cfg_depth_log2;
    depth    = ONE_C << lg_eff;
    depth_m1 = depth - ONE_C;
    mask     = depth_m1[ADDR_W-1:0];
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    win_d    = win_q;
    mode_d   = mode_q;
    err_d    = err_q;

    wr_go    = wr_en && (count_q != depth);
    wr_bad   = wr_en && (count_q == depth);
    start    = rd_req && (state_q == ST_IDLE);
    win_ok   = (cfg_win != '0) && (count_q >= cfg_win);
    rd_go    = start && win_ok;
    rd_bad   = start && !win_ok;
    fin      = (state_q == ST_STREAM) && ({1'b0, idx_q} == (win_q - ONE_C));
    popn     = mode_q ? ONE_C : win_q;
    pop_amt  = fin ? popn : '0;

    wr_sum   = {1'b0, wr_off_q} + (wr_go ? ONE_C : '0);
    wr_off_d = wr_sum[ADDR_W-1:0] & mask;
    rd_sum   = {1'b0, rd_off_q} + pop_amt;
    rd_off_d = rd_sum[ADDR_W-1:0] & mask;
    count_d  = count_q + (wr_go ? ONE_C : '0) - pop_amt;

    case (state_q)
      ST_IDLE: begin
        if (rd_go) begin
          state_d = ST_STREAM;
          idx_d   = '0;
          win_d   = cfg_win;
          mode_d  = rd_mode;
        end
      end
      ST_STREAM: begin
        if (fin) state_d = ST_IDLE;
        else     idx_d   = idx_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase

    if (wr_bad || rd_bad) err_d = 1'b1;
    else if (err_clr)     err_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      win_q    <= '0;
      mode_q   <= 1'b0;
      wr_off_q <= '0;
      rd_off_q <= '0;
      count_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (rd_go) begin
        win_q  <= win_d;
        mode_q <= mode_d;
      end
      if (wr_go) wr_off_q <= wr_off_d;
      if (fin)   rd_off_q <= rd_off_d;
      if (wr_go || fin) count_q <= count_d;
      err_q <= err_d;
    end
  end

  assign wr_off        = wr_off_q;
  assign rd_off        = rd_off_q;
  assign rd_addr_off   = (rd_off_q + idx_q) & mask;
  assign rd_issue      = (state_q == ST_STREAM);
  assign rd_issue_last = fin;
  assign count         = count_q;
  assign busy          = (state_q == ST_STREAM);
  assign empty         = (count_q == '0);
  assign full          = (count_q == depth);
  assign err           = err_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= depth); // R3
  AST_WR_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> (err_q && wr_off_q == $past(wr_off_q))); // R3
  AST_STD_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !mode_q) |=> (count_q == $past(count_q) - $past(win_q)
                          + {{ADDR_W{1'b0}}, $past(wr_go)})); // R4
  AST_TAP_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && mode_q && mask != '0) |=>
      (((rd_off_q - $past(rd_off_q)) & $past(mask)) == ADDR_W'(1))); // R5
  AST_SHORT_READ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |=> (err_q && state_q == ST_IDLE && rd_off_q == $past(rd_off_q))); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STREAM && !fin) |=> (state_q == ST_STREAM)); // R10
endmodule

// File: rtl/wfifo_top.sv
module wfifo_top #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int LOG_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LOG_W-1:0]  cfg_depth_log2,
  input  logic [ADDR_W:0]   cfg_win,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic              rd_mode,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_last,
  output logic              busy,
  output logic              empty,
  output logic              full,
  output logic              err,
  output logic [ADDR_W:0]   count,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] wr_ptr
);
  if (DATA_W != 8 && DATA_W != 16 && DATA_W != 32) begin : g_bad_width
    $error("wfifo_top: DATA_W must be 8, 16 or 32");
  end

  logic              rst_n_s;
  logic [ADDR_W-1:0] mask, wr_off, rd_off, rd_addr_off, rd_addr_phys;
  logic              wr_go, rd_issue, rd_issue_last;

  wfifo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  wfifo_ctrl #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .cfg_depth_log2 (cfg_depth_log2),
    .cfg_win        (cfg_win),
    .wr_en          (wr_en),
    .rd_req         (rd_req),
    .rd_mode        (rd_mode),
    .err_clr        (err_clr),
    .mask           (mask),
    .wr_off         (wr_off),
    .rd_off         (rd_off),
    .rd_addr_off    (rd_addr_off),
    .wr_go          (wr_go),
    .rd_issue       (rd_issue),
    .rd_issue_last  (rd_issue_last),
    .count          (count),
    .busy           (busy),
    .empty          (empty),
    .full           (full),
    .err            (err)
  );

  wfifo_map #(.ADDR_W(ADDR_W)) u_map_wr (
    .base (cfg_base), .mask (mask), .off (wr_off), .phys (wr_ptr)
  );
  wfifo_map #(.ADDR_W(ADDR_W)) u_map_rd (
    .base (cfg_base), .mask (mask), .off (rd_off), .phys (rd_ptr)
  );
  wfifo_map #(.ADDR_W(ADDR_W)) u_map_win (
    .base (cfg_base), .mask (mask), .off (rd_addr_off), .phys (rd_addr_phys)
  );

  wfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .we       (wr_go),
    .waddr    (wr_ptr),
    .wdata    (wr_data),
    .re       (rd_issue),
    .raddr    (rd_addr_phys),
    .rlast    (rd_issue_last),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_last  (rd_last)
  );
endmodule

// File: tb/wfifo_top_tb_top.sv
module wfifo_top_tb_top;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] cfg_base;
  logic [LW-1:0] cfg_depth_log2;
  logic [AW:0]   cfg_win;
  logic          wr_en, rd_req, rd_mode, err_clr;
  logic [DW-1:0] wr_data, rd_data;
  logic          rd_valid, rd_last, busy, empty, full, err;
  logic [AW:0]   count;
  logic [AW-1:0] rd_ptr, wr_ptr;

  int n_chk = 0;
  int n_fail = 0;

  // bench reference state
  logic [DW-1:0] ref_mem [64];
  int ref_wr = 0;
  int ref_rd = 0;
  int ref_cnt = 0;
  int ref_depth = 8;

  always #2 clk = ~clk;

  wfifo_top #(.DATA_W(DW), .ADDR_W(AW), .LOG_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_depth_log2(cfg_depth_log2),
    .cfg_win(cfg_win), .wr_en(wr_en), .wr_data(wr_data), .rd_req(rd_req),
    .rd_mode(rd_mode), .err_clr(err_clr), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_last(rd_last), .busy(busy), .empty(empty), .full(full), .err(err),
    .count(count), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] phys(input int off);
    logic [AW-1:0] m;
    m = AW'(ref_depth - 1);
    return (cfg_base & ~m) | (AW'(off) & m);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic push(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (ref_cnt < ref_depth) begin
      ref_mem[ref_wr] = d;
      ref_wr = (ref_wr + 1) % ref_depth;
      ref_cnt++;
    end
  endtask

  task automatic rd_window(input logic mode, input int n, input bit poke, input string tag);
    bit ok;
    int pop;
    ok = (n != 0) && (ref_cnt >= n);
    rd_req = 1'b1; rd_mode = mode; cfg_win = (AW+1)'(n);
    @(negedge clk);
    rd_req = 1'b0;
    if (!ok) begin
      chk({tag, " abort err"}, err, 1);
      chk({tag, " abort busy"}, busy, 0);
      chk({tag, " abort count"}, count, ref_cnt);
      chk({tag, " abort rd_ptr"}, rd_ptr, phys(ref_rd));
      @(negedge clk);
      chk({tag, " abort no data"}, rd_valid, 0);
      return;
    end
    chk({tag, " busy"}, busy, 1);
    for (int k = 0; k < n; k++) begin
      if (poke && k == 0) begin
        rd_req = 1'b1; wr_en = 1'b1; wr_data = 16'hB000;
      end
      @(negedge clk);
      if (poke && k == 0) begin
        rd_req = 1'b0; wr_en = 1'b0;
        ref_mem[ref_wr] = 16'hB000;
        ref_wr = (ref_wr + 1) % ref_depth;
        ref_cnt++;
      end
      chk({tag, " valid"}, rd_valid, 1);
      chk({tag, " data"}, rd_data, ref_mem[(ref_rd + k) % ref_depth]);
      chk({tag, " last"}, rd_last, (k == n - 1));
    end
    pop = mode ? 1 : n;
    ref_rd = (ref_rd + pop) % ref_depth;
    ref_cnt -= pop;
    chk({tag, " count"}, count, ref_cnt);
    chk({tag, " rd_ptr"}, rd_ptr, phys(ref_rd));
    chk({tag, " idle"}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 err", err, 0);
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 R8 wr_ptr", wr_ptr, 6'd40);
    chk("R1 R8 rd_ptr", rd_ptr, 6'd40);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) begin
      push(16'hA000 + 16'(i));
      chk("R2 count", count, i + 1);
      chk("R3 full only at depth", full, (i == 7));
    end
    chk("R2 wr_ptr wrap", wr_ptr, 6'd40);
    push(16'hDEAD);
    chk("R3 write-full err", err, 1);
    chk("R3 write-full count", count, 8);
    chk("R3 write-full wr_ptr", wr_ptr, 6'd40);
    repeat (3) @(negedge clk);
    chk("R7 err sticky", err, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk("R7 err cleared", err, 0);
  endtask

  task automatic t_reads();
    rd_window(1'b0, 3, 1'b0, "R4 block");
    chk("R4 not full", full, 0);
    rd_window(1'b1, 4, 1'b0, "R5 tap1");
    rd_window(1'b1, 4, 1'b0, "R5 tap2");
  endtask

  task automatic t_abort();
    rd_window(1'b1, 4, 1'b0, "R6 short");
    rd_req = 1'b1; cfg_win = 7'd4; err_clr = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; err_clr = 1'b0;
    chk("R7 set wins over clear", err, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk("R7 clear", err, 0);
    rd_window(1'b0, 0, 1'b0, "R6 zero window");
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_busy_wrap();
    rd_window(1'b0, 2, 1'b1, "R10 poke");
    chk("R10 no extra read err", err, 0);
    rd_window(1'b1, 2, 1'b0, "R5 wrap tap");
    rd_window(1'b0, 1, 1'b0, "R4 drain");
    chk("R6 empty flag", empty, 1);
    rd_window(1'b0, 1, 1'b0, "R6 empty read");
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_depth();
    cfg_depth_log2 = 3'd7;
    ref_depth = 64;
    @(negedge clk);
    chk("R8 R9 wr_ptr at depth 64", wr_ptr, phys(ref_wr));
    for (int i = 0; i < 64; i++) begin
      push(16'hC000 + 16'(i));
      if (i == 62) chk("R9 not full at 63", full, 0);
    end
    chk("R9 full at clamped depth", full, 1);
    chk("R9 count 64", count, 64);
    rd_window(1'b0, 64, 1'b0, "R9 drain 64");
    chk("R9 empty after drain", empty, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_base = 6'b101011; cfg_depth_log2 = 3'd3; cfg_win = 7'd1;
    wr_en = 1'b0; wr_data = '0; rd_req = 1'b0; rd_mode = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_reads();
    t_abort();
    t_busy_wrap();
    t_depth();
    finish_run();
  end
endmodule